// File: doc/BRIEF.md
# Reorder Buffer with Bandwidth-Limited Squash

This block is a circular reorder buffer for an out-of-order core. Instructions enter in program order at the tail, each with a PC, a next-PC and a sequence number that grows with program order. Each slot also holds a ready-to-commit flag and a squashed flag. Only the entry at the head can retire, and only once its ready flag is set. Execution units set that flag by slot index. The index comes from `ins_slot`, which shows the slot the next insertion will take.

A squash request carries a target sequence number. The buffer does not delete anything. Starting at the tail, a walker moves toward the head and processes at most `SQW` entries per cycle. Each entry it passes is flagged as squashed and forced ready, so it drains out through normal retirement. The walk ends when it meets the target entry, which is left untouched, or after it has processed the head entry. `sq_done` is low while a walk is in progress. During that time new insertions are refused, but retirement carries on.

Top module: `reorder_buf`

## Requirements
- R1: Capacity is `DEPTH`. With `DEPTH` entries held, `free_cnt` reads 0, and presenting an insertion in that state is illegal.
- R2: An accepted insertion writes the entry at the slot shown on `ins_slot`. From the next cycle on, `tail_pc` and `tail_seq` show it. Insertion into an empty buffer places the entry at the head position, so it also appears on the head outputs.
- R3: Asserting `ret` removes exactly the head entry. The next-oldest entry then appears on `head_pc`, `head_npc` and `head_seq`. `ret` is legal only while `head_ready` is 1.
- R4: `head_ready` is 0 whenever the buffer is empty. Otherwise it equals the head entry's ready flag. That flag is cleared when the entry is inserted and set by `rdy_valid` with `rdy_idx` equal to its slot.
- R5: `free_cnt` always equals `DEPTH` minus the number of entries held. It reads `DEPTH` after reset.
- R6: A request on `sq_req` is accepted only when `sq_done` is 1 and the buffer is not empty. The target is then captured and `sq_done` is 0 from the next cycle. A request made while the buffer is empty is ignored and `sq_done` stays 1.
- R7: Each cycle after acceptance, the walker processes up to `SQW` entries, from the tail toward the head. Every processed entry gets its squashed flag and its ready flag set, and it later retires with `head_squashed` = 1.
- R8: The walk ends on reaching the entry whose sequence number equals the target. That entry is not squashed. With n entries younger than the target, `sq_done` returns to 1 exactly floor(n/`SQW`)+1 cycles after acceptance.
- R9: If no entry matches the target, the walk ends after it squashes the head entry. `sq_done` returns to 1 exactly ceil(n/`SQW`) cycles after acceptance, where n is the occupancy.
- R10: While `sq_done` is 0, and in the cycle a squash request is accepted, `ins_valid` is ignored. `free_cnt`, `tail_pc` and `tail_seq` are unchanged by it.
- R11: Retirement continues while a squash walk is in progress, and `free_cnt` counts it.
- R12: Slot indices wrap modulo `DEPTH`. The first insertion after reset takes slot 0, and each later one takes (head index + occupancy) mod `DEPTH`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | Insert an entry at the tail this cycle |
| ins_pc | input | PCW | PC of the inserted entry |
| ins_npc | input | PCW | Next-PC of the inserted entry |
| ins_seq | input | SEQW | Sequence number of the inserted entry |
| ins_slot | output | log2(DEPTH) | Slot the next insertion will occupy |
| rdy_valid | input | 1 | Mark slot `rdy_idx` ready to commit |
| rdy_idx | input | log2(DEPTH) | Slot to mark ready |
| ret | input | 1 | Retire the head entry |
| sq_req | input | 1 | Start a squash |
| sq_seq | input | SEQW | Target sequence number of the squash |
| sq_done | output | 1 | No squash walk in progress |
| head_ready | output | 1 | Head entry present and ready to commit |
| head_squashed | output | 1 | Squashed flag of the head entry |
| head_pc | output | PCW | PC of the head entry |
| head_npc | output | PCW | Next-PC of the head entry |
| head_seq | output | SEQW | Sequence number of the head entry |
| tail_pc | output | PCW | PC of the tail entry |
| tail_seq | output | SEQW | Sequence number of the tail entry |
| free_cnt | output | log2(DEPTH+1) | Number of free slots |

## Verification
The bench builds the buffer with `DEPTH` = 8 and `SQW` = 2. With this capacity a handful of insertions is enough to fill it, and a second fill wraps the indices past slot 7. With a walk width of 2, a squash of four or five entries takes several cycles, so the exact cycle counts of R8 and R9 can be measured. It also leaves a middle cycle of the walk in which a refused insertion and a concurrent retirement can be driven.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic {
    WK_IDLE = 1'b0,
    WK_RUN  = 1'b1
  } walk_st_e;
endpackage

// File: rtl/rob_ctrl.sv
module rob_ctrl #(
  parameter  int DEPTH = 16,
  localparam int IW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ins_go,
  input  logic          ret_go,
  output logic [IW-1:0] head_idx,
  output logic [IW-1:0] tail_idx,
  output logic [IW-1:0] slot_idx,
  output logic [CW-1:0] occ
);
  logic [IW-1:0] head_q, head_d, tail_q, tail_d;
  logic [CW-1:0] cnt_q, cnt_d;

  function automatic logic [IW-1:0] inc(input logic [IW-1:0] p);
    return (p == IW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // Empty buffer: the next entry lands on the head position.
  assign slot_idx = (cnt_q == '0) ? head_q : inc(tail_q);

  always_comb begin
    head_d = head_q;
    tail_d = tail_q;
    cnt_d  = cnt_q;
    if (ins_go) tail_d = slot_idx;
    if (ret_go) head_d = inc(head_q);
    case ({ins_go, ret_go})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else if (ins_go || ret_go) begin
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
    end
  end

  assign head_idx = head_q;
  assign tail_idx = tail_q;
  assign occ      = cnt_q;
endmodule

// File: rtl/rob_store.sv
module rob_store #(
  parameter  int DEPTH = 16,
  parameter  int PCW   = 32,
  parameter  int SEQW  = 16,
  localparam int IW    = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [IW-1:0]   wr_idx,
  input  logic [PCW-1:0]  wr_pc,
  input  logic [PCW-1:0]  wr_npc,
  input  logic [SEQW-1:0] wr_seq,
  input  logic            rdy_en,
  input  logic [IW-1:0]   rdy_idx,
  input  logic [DEPTH-1:0] sq_mask,
  input  logic [IW-1:0]   head_idx,
  input  logic [IW-1:0]   tail_idx,
  output logic [PCW-1:0]  head_pc,
  output logic [PCW-1:0]  head_npc,
  output logic [SEQW-1:0] head_seq,
  output logic            head_rdy,
  output logic            head_sqd,
  output logic [PCW-1:0]  tail_pc,
  output logic [SEQW-1:0] tail_seq,
  output logic [SEQW-1:0] seq_arr [DEPTH]
);
  logic [PCW-1:0]   pc_q  [DEPTH];
  logic [PCW-1:0]   npc_q [DEPTH];
  logic [SEQW-1:0]  seq_q [DEPTH];
  logic [DEPTH-1:0] rdy_q, rdy_d, sqd_q, sqd_d;
  logic [DEPTH-1:0] flag_en;

  // Flag next state per slot: insert clears, mark sets ready, squash sets both.
  for (genvar s = 0; s < DEPTH; s++) begin : g_flag
    logic hit_wr, hit_rdy;
    assign hit_wr  = wr_en  && (wr_idx  == IW'(s));
    assign hit_rdy = rdy_en && (rdy_idx == IW'(s));
    assign flag_en[s] = hit_wr || hit_rdy || sq_mask[s];
    assign rdy_d[s] = sq_mask[s] || hit_rdy || (rdy_q[s] && !hit_wr);
    assign sqd_d[s] = sq_mask[s] || (sqd_q[s] && !hit_wr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q <= '0;
      sqd_q <= '0;
    end else if (|flag_en) begin
      rdy_q <= rdy_d;
      sqd_q <= sqd_d;
    end
  end

  // Payload needs no reset: it is only read while the slot is occupied.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      pc_q[wr_idx]  <= wr_pc;
      npc_q[wr_idx] <= wr_npc;
      seq_q[wr_idx] <= wr_seq;
    end
  end

  assign head_pc  = pc_q[head_idx];
  assign head_npc = npc_q[head_idx];
  assign head_seq = seq_q[head_idx];
  assign head_rdy = rdy_q[head_idx];
  assign head_sqd = sqd_q[head_idx];
  assign tail_pc  = pc_q[tail_idx];
  assign tail_seq = seq_q[tail_idx];

  for (genvar s = 0; s < DEPTH; s++) begin : g_seq
    assign seq_arr[s] = seq_q[s];
  end
endmodule

// File: rtl/rob_walk.sv
module rob_walk
  import rob_pkg::*;
#(
  parameter  int DEPTH = 16,
  parameter  int SQW   = 4,
  parameter  int SEQW  = 16,
  localparam int IW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [SEQW-1:0]  tgt,
  input  logic [IW-1:0]    tail_idx,
  input  logic [IW-1:0]    head_idx,
  input  logic             empty,
  input  logic [SEQW-1:0]  seq_arr [DEPTH],
  output logic             done,
  output logic [DEPTH-1:0] sq_mask
);
  walk_st_e        st_q, st_d;
  logic [IW-1:0]   pos_q, pos_d, cur;
  logic [SEQW-1:0] tgt_q;
  logic            fin, live;

  function automatic logic [IW-1:0] dec(input logic [IW-1:0] p);
    return (p == '0) ? IW'(DEPTH - 1) : p - 1'b1;
  endfunction

  // Up to SQW entries per cycle, stopping at the target or after the head.
  always_comb begin
    sq_mask = '0;
    fin     = 1'b0;
    cur     = pos_q;
    live    = (st_q == WK_RUN);
    if (live && empty) begin
      fin  = 1'b1;
      live = 1'b0;
    end
    for (int k = 0; k < SQW; k++) begin
      if (live) begin
        if (seq_arr[cur] == tgt_q) begin
          fin  = 1'b1;
          live = 1'b0;
        end else begin
          sq_mask[cur] = 1'b1;
          if (cur == head_idx) begin
            fin  = 1'b1;
            live = 1'b0;
          end else begin
            cur = dec(cur);
          end
        end
      end
    end
  end

  always_comb begin
    st_d  = st_q;
    pos_d = pos_q;
    if (st_q == WK_IDLE) begin
      if (start) begin
        st_d  = WK_RUN;
        pos_d = tail_idx;
      end
    end else begin
      pos_d = cur;
      if (fin) st_d = WK_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= WK_IDLE;
      pos_q <= '0;
      tgt_q <= '0;
    end else if (start || st_q == WK_RUN) begin
      st_q  <= st_d;
      pos_q <= pos_d;
      if (st_q == WK_IDLE) tgt_q <= tgt;
    end
  end

  assign done = (st_q == WK_IDLE);
endmodule

// File: rtl/reorder_buf.sv
module reorder_buf #(
  parameter  int DEPTH = 16,
  parameter  int SQW   = 4,
  parameter  int PCW   = 32,
  parameter  int SEQW  = 16,
  localparam int IW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ins_valid,
  input  logic [PCW-1:0]  ins_pc,
  input  logic [PCW-1:0]  ins_npc,
  input  logic [SEQW-1:0] ins_seq,
  output logic [IW-1:0]   ins_slot,
  input  logic            rdy_valid,
  input  logic [IW-1:0]   rdy_idx,
  input  logic            ret,
  input  logic            sq_req,
  input  logic [SEQW-1:0] sq_seq,
  output logic            sq_done,
  output logic            head_ready,
  output logic            head_squashed,
  output logic [PCW-1:0]  head_pc,
  output logic [PCW-1:0]  head_npc,
  output logic [SEQW-1:0] head_seq,
  output logic [PCW-1:0]  tail_pc,
  output logic [SEQW-1:0] tail_seq,
  output logic [CW-1:0]   free_cnt
);
  logic [IW-1:0]    head_idx, tail_idx;
  logic [CW-1:0]    occ;
  logic             empty, ins_go, ret_go, sq_start, head_rdy_raw;
  logic [DEPTH-1:0] sq_mask;
  logic [SEQW-1:0]  seq_arr [DEPTH];

  assign empty    = (occ == '0);
  assign sq_start = sq_req && sq_done && !empty;
  // A squash request wins over an insertion in the same cycle.
  assign ins_go   = ins_valid && sq_done && !sq_req;
  assign ret_go   = ret && head_ready;

  rob_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .ins_go   (ins_go),
    .ret_go   (ret_go),
    .head_idx (head_idx),
    .tail_idx (tail_idx),
    .slot_idx (ins_slot),
    .occ      (occ)
  );

  rob_store #(.DEPTH(DEPTH), .PCW(PCW), .SEQW(SEQW)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (ins_go),
    .wr_idx   (ins_slot),
    .wr_pc    (ins_pc),
    .wr_npc   (ins_npc),
    .wr_seq   (ins_seq),
    .rdy_en   (rdy_valid),
    .rdy_idx  (rdy_idx),
    .sq_mask  (sq_mask),
    .head_idx (head_idx),
    .tail_idx (tail_idx),
    .head_pc  (head_pc),
    .head_npc (head_npc),
    .head_seq (head_seq),
    .head_rdy (head_rdy_raw),
    .head_sqd (head_squashed),
    .tail_pc  (tail_pc),
    .tail_seq (tail_seq),
    .seq_arr  (seq_arr)
  );

  rob_walk #(.DEPTH(DEPTH), .SQW(SQW), .SEQW(SEQW)) u_walk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (sq_start),
    .tgt      (sq_seq),
    .tail_idx (tail_idx),
    .head_idx (head_idx),
    .empty    (empty),
    .seq_arr  (seq_arr),
    .done     (sq_done),
    .sq_mask  (sq_mask)
  );

  assign head_ready = !empty && head_rdy_raw;
  assign free_cnt   = CW'(DEPTH) - occ;
endmodule

// File: rtl/reorder_buf_chk.sv
module reorder_buf_chk #(
  parameter  int DEPTH = 16,
  parameter  int SEQW  = 16,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ins_valid,
  input logic            ret,
  input logic            sq_req,
  input logic            sq_done,
  input logic            head_ready,
  input logic [SEQW-1:0] tail_seq,
  input logic [CW-1:0]   free_cnt
);
  assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && sq_done && !sq_req) |-> (free_cnt != '0));

  assert_retire_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ret |-> head_ready);

  assert_empty_unready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (free_cnt == CW'(DEPTH)) |-> !head_ready);

  assert_free_insert_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && sq_done && !sq_req && !ret) |=> (free_cnt == $past(free_cnt) - 1'b1));

  assert_squash_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_req && sq_done && free_cnt != CW'(DEPTH)) |=> !sq_done);

  assert_done_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_done && !sq_req) |=> sq_done);

  assert_tail_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !sq_done |=> $stable(tail_seq));

  assert_free_retire_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ret && !(ins_valid && sq_done && !sq_req)) |=> (free_cnt == $past(free_cnt) + 1'b1));
endmodule

bind reorder_buf reorder_buf_chk #(.DEPTH(DEPTH), .SEQW(SEQW)) u_chk (.*);

// File: tb/test_reorder_buf.sv
module test_reorder_buf;
  localparam int D   = 8;
  localparam int SQW = 2;
  localparam int IW  = $clog2(D);
  localparam int CW  = $clog2(D + 1);

  logic        clk, rst_n;
  logic        ins_valid, rdy_valid, ret, sq_req;
  logic [31:0] ins_pc, ins_npc;
  logic [15:0] ins_seq, sq_seq;
  logic [IW-1:0] ins_slot, rdy_idx;
  logic        sq_done, head_ready, head_squashed;
  logic [31:0] head_pc, head_npc, tail_pc;
  logic [15:0] head_seq, tail_seq;
  logic [CW-1:0] free_cnt;

  reorder_buf #(.DEPTH(D), .SQW(SQW), .PCW(32), .SEQW(16)) i_reorder_buf (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_pc(ins_pc),
    .ins_npc(ins_npc), .ins_seq(ins_seq), .ins_slot(ins_slot),
    .rdy_valid(rdy_valid), .rdy_idx(rdy_idx), .ret(ret), .sq_req(sq_req),
    .sq_seq(sq_seq), .sq_done(sq_done), .head_ready(head_ready),
    .head_squashed(head_squashed), .head_pc(head_pc), .head_npc(head_npc),
    .head_seq(head_seq), .tail_pc(tail_pc), .tail_seq(tail_seq),
    .free_cnt(free_cnt)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct {
    int          slot;
    logic [31:0] pc;
    logic [31:0] npc;
    logic [15:0] seq;
    bit          rdy;
    bit          sqd;
  } item_t;

  item_t q[$];
  int    mhead = 0;
  int    n_chk = 0, n_bad = 0;
  bit    finished = 1'b0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Driver: insert one entry and push its expectation.
  task automatic do_ins(input logic [15:0] s);
    item_t it;
    @(negedge clk);
    chk("R12 ins_slot", ins_slot, (mhead + q.size()) % D);
    it.slot = (mhead + q.size()) % D;
    it.pc = 32'h4000 + 32'(s) * 4;
    it.npc = it.pc + 4;
    it.seq = s;
    it.rdy = 1'b0;
    it.sqd = 1'b0;
    ins_valid = 1'b1; ins_pc = it.pc; ins_npc = it.npc; ins_seq = s;
    @(negedge clk);
    ins_valid = 1'b0;
    q.push_back(it);
    chk("R2 tail_seq", tail_seq, s);
    chk("R2 tail_pc", tail_pc, it.pc);
    chk("R5 free_cnt", free_cnt, D - q.size());
  endtask

  task automatic mark(input int slot);
    @(negedge clk);
    rdy_valid = 1'b1; rdy_idx = IW'(slot);
    @(negedge clk);
    rdy_valid = 1'b0;
    foreach (q[i]) if (q[i].slot == slot) q[i].rdy = 1'b1;
  endtask

  // Monitor side: compare head against the oldest expectation.
  task automatic cmp_head();
    chk("R3 head_pc", head_pc, q[0].pc);
    chk("R3 head_npc", head_npc, q[0].npc);
    chk("R3 head_seq", head_seq, q[0].seq);
    chk("R4 head_ready", head_ready, q[0].rdy);
    chk("R7 head_squashed", head_squashed, q[0].sqd);
  endtask

  task automatic do_ret();
    @(negedge clk);
    cmp_head();
    ret = 1'b1;
    @(negedge clk);
    ret = 1'b0;
    void'(q.pop_front());
    mhead = (mhead + 1) % D;
    chk("R3 free_cnt after retire", free_cnt, D - q.size());
    if (q.size() == 0) chk("R4 head_ready empty", head_ready, 0);
  endtask

  // Squash; side=1 also tries an insert and retires the head in the first walk cycle.
  task automatic do_squash(input logic [15:0] tgt, input bit side);
    int n = 0, cyc = 0, exp_c, fb;
    bit found = 1'b0;
    logic [15:0] tseq;
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].seq == tgt) begin found = 1'b1; break; end
      q[i].rdy = 1'b1; q[i].sqd = 1'b1; n++;
    end
    exp_c = found ? (n / SQW + 1) : ((n + SQW - 1) / SQW);
    @(negedge clk);
    sq_req = 1'b1; sq_seq = tgt;
    ins_valid = side; ins_pc = 32'hDEAD; ins_npc = 32'hBEEF; ins_seq = 16'h7777;
    @(negedge clk);
    sq_req = 1'b0;
    chk("R6 sq_done low", sq_done, 0);
    chk("R10 no insert on request", free_cnt, D - q.size());
    tseq = tail_seq;
    fb = free_cnt;
    if (side) begin
      cmp_head();
      ret = 1'b1;
    end
    do begin
      @(negedge clk);
      cyc++;
      if (cyc == 1 && side) begin
        ret = 1'b0; ins_valid = 1'b0;
        void'(q.pop_front());
        mhead = (mhead + 1) % D;
        chk("R11 retire during squash", free_cnt, fb + 1);
        chk("R10 tail frozen", tail_seq, tseq);
      end
    end while (!sq_done && cyc < 40);
    ins_valid = 1'b0;
    if (found) chk("R8 walk cycles", cyc, exp_c);
    else       chk("R9 walk cycles", cyc, exp_c);
  endtask

  initial begin
    #(4 * 20000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!finished) begin
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ins_valid = 1'b0; rdy_valid = 1'b0; ret = 1'b0; sq_req = 1'b0;
    ins_pc = '0; ins_npc = '0; ins_seq = '0; sq_seq = '0; rdy_idx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R5 reset free_cnt", free_cnt, D);
    chk("R4 reset head_ready", head_ready, 0);
    chk("R6 reset sq_done", sq_done, 1);
    chk("R12 reset ins_slot", ins_slot, 0);

    do_ins(10); do_ins(11); do_ins(12);
    chk("R4 unready head", head_ready, 0);
    mark(q[0].slot); do_ret();
    mark(q[0].slot); mark(q[1].slot);
    do_ret(); do_ret();

    for (int s = 20; s < 28; s++) do_ins(16'(s));
    chk("R1 full free_cnt", free_cnt, 0);
    mark(q[0].slot); mark(q[1].slot);
    do_ret(); do_ret();
    mark(q[0].slot);
    do_squash(16'd23, 1'b1);
    mark(q[0].slot);
    while (q.size() != 0) do_ret();

    for (int s = 30; s < 35; s++) do_ins(16'(s));
    do_squash(16'd5, 1'b0);
    while (q.size() != 0) do_ret();

    @(negedge clk);
    sq_req = 1'b1; sq_seq = 16'd1;
    @(negedge clk);
    sq_req = 1'b0;
    chk("R6 empty request ignored", sq_done, 1);

    do_ins(40); do_ins(41);
    do_squash(16'd41, 1'b0);
    mark(q[0].slot); mark(q[1].slot);
    do_ret(); do_ret();

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule